// File: doc/BRIEF.md
# Multi-Tap Complex Correlator Bank

This block despreads the complex baseband samples of one tracking channel. It forms five replicas of the local spreading code at increasing delays: very-early, early, prompt, late and very-late. It multiplies every valid I/Q sample by each replica and integrates the ten signed products, one I and one Q per tap, in wide saturating accumulators. When a dump strobe arrives, it latches all ten sums to the outputs and starts the next integration at once.

The replicas come from two code delay lines. Each line has its own code input, its own base offset and its own tap spacing. A per-tap select bit chooses which line feeds each tap. One channel can therefore track both the pilot and the data component of a signal, or place a pair of very-early/very-late taps for a binary-offset-carrier signal. The carrier wipe-off and the loop filters sit outside this block.

Top module: `multitap_correlator`

## Requirements
- R1: After a synchronous active-low reset, all ten result fields read zero and `res_vld` is low. Both delay lines then hold chip value 0.
- R2: In every cycle with `smp_vld` high, each tap adds its product to its I and Q accumulators. The product is +sample when the tap chip is 1 and −sample when it is 0. Samples are 3-bit two's complement. In cycles with `smp_vld` low, the accumulators, the delay lines and the outputs do not change, whatever the sample and code inputs carry.
- R3: In the cycle after `dump` is high, the outputs show the sum of all valid samples accumulated since the previous dump. That sum excludes the sample presented in the dump cycle. `res_vld` is high in exactly that cycle. Between dumps, the outputs hold their values.
- R4: A valid sample presented in the dump cycle becomes the first term of the next integration. A dump without a valid sample restarts the accumulators at zero.
- R5: Tap t, with index 0 = very-early, 1 = early, 2 = prompt, 3 = late and 4 = very-late, uses the code chip that arrived d valid samples before the current one. The delay is d = offset + t·spacing, limited to `MAX_DLY`. d = 0 is the chip presented with the current sample. Code chips arrive only with valid samples. Before any chip has arrived, a line supplies chip 0.
- R6: Bit t of `tap_src` selects the source for tap t: 0 takes line A (`code_a`, `dly_ofs_a`, `dly_spc_a`) and 1 takes line B (`code_b`, `dly_ofs_b`, `dly_spc_b`). The two lines are configured independently.
- R7: The accumulators saturate at the signed limits of `ACC_W` bits, −2^(ACC_W−1) and 2^(ACC_W−1)−1, instead of wrapping.
- R8: Tap t's results sit at bits [t·ACC_W +: ACC_W] of `res_i` and `res_q`, each in two's complement. The default `ACC_W` is 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample and code chips valid this cycle |
| smp_i | input | SMP_W (3) | In-phase sample, two's complement |
| smp_q | input | SMP_W (3) | Quadrature sample, two's complement |
| code_a | input | 1 | Code chip for delay line A |
| code_b | input | 1 | Code chip for delay line B |
| dly_ofs_a | input | OFS_W (5) | Base delay of line A, in samples |
| dly_spc_a | input | SPC_W (4) | Tap spacing of line A, in samples |
| dly_ofs_b | input | OFS_W (5) | Base delay of line B, in samples |
| dly_spc_b | input | SPC_W (4) | Tap spacing of line B, in samples |
| tap_src | input | 5 | Per-tap line select, 0 = A, 1 = B |
| dump | input | 1 | Integration dump strobe |
| res_i | output | 5·ACC_W | Latched I results, tap 0 in the low field |
| res_q | output | 5·ACC_W | Latched Q results, tap 0 in the low field |
| res_vld | output | 1 | One-cycle pulse after a dump |

## Verification
Pseudo-random samples and chips are run with several delay settings. Zero spacing makes all five taps identical. Small spacings on both lines, with mixed `tap_src` masks, show whether each tap reads the right line and depth. Large offset and spacing exceed `MAX_DLY` and so exercise the depth limit. A run with gaps in `smp_vld`, where the gap cycles carry random junk, shows whether invalid cycles leak into the sums or shift the code lines. Every run has a mid-stream dump carrying a valid sample and then an empty dump, which separates the latch timing from the restart value. A constant full-scale run of both signs drives a narrow-accumulator instance into both saturation limits, while the default-width instance keeps the unclamped sum.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    // Number of correlator taps: very-early, early, prompt, late, very-late.
    localparam int NTAP = 5;

    // Delay in samples for tap index tap of a line, limited to max_dly.
    function automatic int unsigned tap_delay(input int unsigned ofs,
                                              input int unsigned spc,
                                              input int unsigned tap,
                                              input int unsigned max_dly);
        int unsigned sum;
        sum = ofs + tap * spc;
        return (sum > max_dly) ? max_dly : sum;
    endfunction

endpackage

// File: rtl/mtc_code_delay.sv
// Code delay line. It shifts in one code chip per valid sample and exposes
// NTAP taps at delays ofs + t*spc, limited to MAX_DLY. Delay 0 is the chip
// presented in the current cycle.
// Assumes MAX_DLY >= 2. The stored history resets to chip 0.
module mtc_code_delay #(
    parameter int MAX_DLY = 63,
    parameter int OFS_W   = 5,
    parameter int SPC_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     chip_in,
    input  logic [OFS_W-1:0]         ofs,
    input  logic [SPC_W-1:0]         spc,
    output logic [mtc_pkg::NTAP-1:0] taps
);
    localparam int IDX_W = $clog2(MAX_DLY + 1);

    logic [MAX_DLY-1:0] hist;   // hist[k] holds the chip from k+1 valid samples ago
    logic [MAX_DLY:0]   line;   // line[d] is the chip delayed by d samples

    // Shift history one place on every valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (adv) begin
            hist <= {hist[MAX_DLY-2:0], chip_in};
        end
    end

    // Current chip in front of the stored history.
    always_comb line = {hist, chip_in};

    for (genvar t = 0; t < mtc_pkg::NTAP; t++) begin : g_tap
        logic [IDX_W-1:0] dly;
        // Compute this tap's limited delay from the line configuration.
        always_comb dly = IDX_W'(mtc_pkg::tap_delay(32'(ofs), 32'(spc), t, MAX_DLY));
        assign taps[t] = line[dly];
    end

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> hist[0] == $past(chip_in));

    // R2
    hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist));

endmodule

// File: rtl/mtc_tap_select.sv
// Per-tap source select between the two code delay lines.
// Assumes both tap vectors are already aligned to the tap index order.
module mtc_tap_select (
    input  logic [mtc_pkg::NTAP-1:0] taps_a,
    input  logic [mtc_pkg::NTAP-1:0] taps_b,
    input  logic [mtc_pkg::NTAP-1:0] sel_b,
    output logic [mtc_pkg::NTAP-1:0] taps
);
    for (genvar t = 0; t < mtc_pkg::NTAP; t++) begin : g_sel
        // Pick line B for this tap when its select bit is set.
        always_comb taps[t] = sel_b[t] ? taps_b[t] : taps_a[t];
    end
endmodule

// File: rtl/mtc_accum.sv
// Saturating integrate-and-dump accumulator for one tap and one rail.
// It adds +smp or -smp per valid sample, depending on the chip. On dump it
// latches the running sum and restarts from the current product.
// Assumes ACC_W > SMP_W + 1.
module mtc_accum #(
    parameter int SMP_W = 3,
    parameter int ACC_W = 29
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    dump,
    input  logic signed [SMP_W-1:0] smp,
    input  logic                    chip,
    output logic signed [ACC_W-1:0] result
);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc;
    logic signed [SMP_W:0]   smp_x;
    logic signed [SMP_W:0]   prod;
    logic signed [ACC_W-1:0] prod_x;
    logic signed [ACC_W:0]   sum;
    logic signed [ACC_W-1:0] sum_sat;

    // Form the despread product; one extra bit holds the negated minimum.
    always_comb begin
        smp_x  = {smp[SMP_W-1], smp};
        prod   = chip ? smp_x : -smp_x;
        prod_x = {{(ACC_W-SMP_W-1){prod[SMP_W]}}, prod};
    end

    // Add with one guard bit and clamp to the signed range on overflow.
    always_comb begin
        sum = {acc[ACC_W-1], acc} + {prod_x[ACC_W-1], prod_x};
        if (sum[ACC_W] != sum[ACC_W-1]) begin
            sum_sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            sum_sat = sum[ACC_W-1:0];
        end
    end

    // Integrate valid samples; on dump restart from this cycle's product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (dump) begin
            acc <= adv ? prod_x : '0;
        end else if (adv) begin
            acc <= sum_sat;
        end
    end

    // Capture the finished integration on dump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (dump) begin
            result <= acc;
        end
    end

    // R7
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_MAX && adv && !dump && !prod[SMP_W]) |=> acc == ACC_MAX);

    // R7
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_MIN && adv && !dump && prod[SMP_W]) |=> acc == ACC_MIN);

    // R3
    dump_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> result == $past(acc));

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(result));

    // R2
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !dump) |=> $stable(acc));

    // R4
    empty_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dump && !adv) |=> acc == '0);

endmodule

// File: rtl/multitap_correlator.sv
// Five-tap complex correlator bank for one channel. Two code delay lines
// build the tap replicas, a per-tap select chooses a line for each tap, and
// ten saturating accumulators integrate the despread I and Q samples.
// Assumes the code chips are aligned with smp_vld, and that dump may come in
// any cycle, with or without a valid sample.
module multitap_correlator #(
    parameter int SMP_W   = 3,
    parameter int ACC_W   = 29,
    parameter int MAX_DLY = 63,
    parameter int OFS_W   = 5,
    parameter int SPC_W   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                smp_vld,
    input  logic [SMP_W-1:0]                    smp_i,
    input  logic [SMP_W-1:0]                    smp_q,
    input  logic                                code_a,
    input  logic                                code_b,
    input  logic [OFS_W-1:0]                    dly_ofs_a,
    input  logic [SPC_W-1:0]                    dly_spc_a,
    input  logic [OFS_W-1:0]                    dly_ofs_b,
    input  logic [SPC_W-1:0]                    dly_spc_b,
    input  logic [mtc_pkg::NTAP-1:0]            tap_src,
    input  logic                                dump,
    output logic [mtc_pkg::NTAP*ACC_W-1:0]      res_i,
    output logic [mtc_pkg::NTAP*ACC_W-1:0]      res_q,
    output logic                                res_vld
);
    localparam int NTAP = mtc_pkg::NTAP;

    logic [NTAP-1:0] taps_a;
    logic [NTAP-1:0] taps_b;
    logic [NTAP-1:0] taps;

    mtc_code_delay #(.MAX_DLY(MAX_DLY), .OFS_W(OFS_W), .SPC_W(SPC_W)) line_a_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (smp_vld),
        .chip_in (code_a),
        .ofs     (dly_ofs_a),
        .spc     (dly_spc_a),
        .taps    (taps_a)
    );

    mtc_code_delay #(.MAX_DLY(MAX_DLY), .OFS_W(OFS_W), .SPC_W(SPC_W)) line_b_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (smp_vld),
        .chip_in (code_b),
        .ofs     (dly_ofs_b),
        .spc     (dly_spc_b),
        .taps    (taps_b)
    );

    mtc_tap_select tap_sel_i (
        .taps_a (taps_a),
        .taps_b (taps_b),
        .sel_b  (tap_src),
        .taps   (taps)
    );

    for (genvar t = 0; t < NTAP; t++) begin : g_corr
        logic signed [ACC_W-1:0] r_i;
        logic signed [ACC_W-1:0] r_q;

        mtc_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) acc_i_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (smp_vld),
            .dump   (dump),
            .smp    (smp_i),
            .chip   (taps[t]),
            .result (r_i)
        );

        mtc_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) acc_q_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (smp_vld),
            .dump   (dump),
            .smp    (smp_q),
            .chip   (taps[t]),
            .result (r_q)
        );

        assign res_i[t*ACC_W +: ACC_W] = r_i;
        assign res_q[t*ACC_W +: ACC_W] = r_q;
    end

    // Pulse the result-valid flag in the cycle after each dump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
        end else begin
            res_vld <= dump;
        end
    end

    // R3
    vld_after_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> res_vld);

    // R3
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> !res_vld);

    // R3
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> ($stable(res_i) && $stable(res_q)));

endmodule

// File: tb/multitap_correlator_tb_top.sv
module multitap_correlator_tb_top;
    localparam int AW   = 29;
    localparam int AWS  = 10;
    localparam int MAXD = 63;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             vld = 1'b0;
    logic [2:0]       si = '0;
    logic [2:0]       sq = '0;
    logic             ca = 1'b0;
    logic             cb = 1'b0;
    logic [4:0]       ofs_a = '0;
    logic [3:0]       spc_a = '0;
    logic [4:0]       ofs_b = '0;
    logic [3:0]       spc_b = '0;
    logic [4:0]       sel = '0;
    logic             dmp = 1'b0;
    logic [5*AW-1:0]  oi, oq;
    logic [5*AWS-1:0] ois, oqs;
    logic             ov, ovs;

    multitap_correlator dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(vld), .smp_i(si), .smp_q(sq),
        .code_a(ca), .code_b(cb), .dly_ofs_a(ofs_a), .dly_spc_a(spc_a),
        .dly_ofs_b(ofs_b), .dly_spc_b(spc_b), .tap_src(sel), .dump(dmp),
        .res_i(oi), .res_q(oq), .res_vld(ov)
    );

    multitap_correlator #(.ACC_W(AWS)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(vld), .smp_i(si), .smp_q(sq),
        .code_a(ca), .code_b(cb), .dly_ofs_a(ofs_a), .dly_spc_a(spc_a),
        .dly_ofs_b(ofs_b), .dly_spc_b(spc_b), .tap_src(sel), .dump(dmp),
        .res_i(ois), .res_q(oqs), .res_vld(ovs)
    );

    int errors = 0;
    int checks = 0;

    // Reference model state
    int n;
    bit ha [0:1023];
    bit hb [0:1023];
    int acc_fi [5], acc_fq [5], acc_si [5], acc_sq [5];
    int lat_fi [5], lat_fq [5], lat_si [5], lat_sq [5];
    bit exp_vld;

    typedef struct packed {
        logic [4:0] oa;
        logic [3:0] sa;
        logic [4:0] ob;
        logic [3:0] sb;
        logic [4:0] src;
        logic [1:0] mode;   // 0 random, 1 full-scale constant, 2 random with gaps
        logic [9:0] len;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{5'd0,  4'd1,  5'd3,  4'd2, 5'b00000, 2'd0, 10'd60},
        '{5'd2,  4'd3,  5'd0,  4'd0, 5'b10101, 2'd0, 10'd80},
        '{5'd5,  4'd2,  5'd1,  4'd1, 5'b11111, 2'd2, 10'd90},
        '{5'd31, 4'd15, 5'd7,  4'd4, 5'b01010, 2'd0, 10'd150},
        '{5'd0,  4'd0,  5'd10, 4'd5, 5'b00100, 2'd0, 10'd40},
        '{5'd0,  4'd0,  5'd0,  4'd0, 5'b00000, 2'd1, 10'd200}
    };

    function automatic int sat(input int x, input int w);
        int hi, lo;
        hi = (1 <<< (w - 1)) - 1;
        lo = -(1 <<< (w - 1));
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    function automatic bit tap_chip(input int t);
        int d;
        bit useb;
        useb = sel[t];
        d = useb ? (int'(ofs_b) + t * int'(spc_b)) : (int'(ofs_a) + t * int'(spc_a));
        if (d > MAXD) d = MAXD;
        if (n - d < 0) return 1'b0;
        return useb ? hb[n - d] : ha[n - d];
    endfunction

    task automatic model_reset();
        n = 0;
        exp_vld = 1'b0;
        for (int t = 0; t < 5; t++) begin
            acc_fi[t] = 0; acc_fq[t] = 0; acc_si[t] = 0; acc_sq[t] = 0;
            lat_fi[t] = 0; lat_fq[t] = 0; lat_si[t] = 0; lat_sq[t] = 0;
        end
    endtask

    task automatic check_outs(input string tag);
        int bad;
        bad = 0;
        checks++;
        for (int t = 0; t < 5; t++) begin
            int gfi, gfq, gsi, gsq;
            gfi = int'($signed(oi[t*AW +: AW]));
            gfq = int'($signed(oq[t*AW +: AW]));
            gsi = int'($signed(ois[t*AWS +: AWS]));
            gsq = int'($signed(oqs[t*AWS +: AWS]));
            if (gfi != lat_fi[t]) begin
                bad++; $display("FAIL %s tap%0d I actual=%0d expected=%0d", tag, t, gfi, lat_fi[t]);
            end
            if (gfq != lat_fq[t]) begin
                bad++; $display("FAIL %s tap%0d Q actual=%0d expected=%0d", tag, t, gfq, lat_fq[t]);
            end
            if (gsi != lat_si[t]) begin
                bad++; $display("FAIL %s narrow tap%0d I actual=%0d expected=%0d", tag, t, gsi, lat_si[t]);
            end
            if (gsq != lat_sq[t]) begin
                bad++; $display("FAIL %s narrow tap%0d Q actual=%0d expected=%0d", tag, t, gsq, lat_sq[t]);
            end
        end
        if (bad != 0) errors++;
        checks++;
        if (ov !== exp_vld || ovs !== exp_vld) begin
            errors++;
            $display("FAIL R3 res_vld actual=%b/%b expected=%b", ov, ovs, exp_vld);
        end
    endtask

    // Drive one cycle (entered at a falling edge), update the model, check outputs.
    task automatic step(input bit v, input bit d, input int i, input int q,
                        input bit a, input bit b, input string tag);
        vld = v; dmp = d; si = 3'(i); sq = 3'(q); ca = a; cb = b;
        @(posedge clk);
        if (v) begin
            ha[n] = a;
            hb[n] = b;
        end
        for (int t = 0; t < 5; t++) begin
            int p_i, p_q;
            bit c;
            c = v ? tap_chip(t) : 1'b0;
            p_i = c ? i : -i;
            p_q = c ? q : -q;
            if (d) begin
                lat_fi[t] = acc_fi[t]; lat_fq[t] = acc_fq[t];
                lat_si[t] = acc_si[t]; lat_sq[t] = acc_sq[t];
                acc_fi[t] = v ? p_i : 0; acc_fq[t] = v ? p_q : 0;
                acc_si[t] = v ? p_i : 0; acc_sq[t] = v ? p_q : 0;
            end else if (v) begin
                acc_fi[t] = sat(acc_fi[t] + p_i, AW);
                acc_fq[t] = sat(acc_fq[t] + p_q, AW);
                acc_si[t] = sat(acc_si[t] + p_i, AWS);
                acc_sq[t] = sat(acc_sq[t] + p_q, AWS);
            end
        end
        if (v) n++;
        exp_vld = d;
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vld = 1'b0; dmp = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state on both instances
        check_outs("R1 reset");

        for (int k = 0; k < 6; k++) begin
            vec_t vc;
            vc = VECS[k];
            ofs_a = vc.oa; spc_a = vc.sa; ofs_b = vc.ob; spc_b = vc.sb; sel = vc.src;
            do_reset();
            for (int s = 0; s < int'(vc.len); s++) begin
                bit v, d, a, b;
                int i, q;
                d = (vc.mode != 2'd1) && (s == int'(vc.len) / 2);
                if (vc.mode == 2'd1) begin
                    v = 1'b1; i = 3; q = -4; a = 1'b1; b = 1'b1;
                end else begin
                    v = (vc.mode == 2'd2) ? (($urandom % 3) != 0) : 1'b1;
                    if (d) v = 1'b1;
                    i = int'($urandom % 8) - 4;
                    q = int'($urandom % 8) - 4;
                    a = 1'($urandom); b = 1'($urandom);
                end
                // R2 R4 R5 R6 R8 (R7 in the full-scale vector)
                step(v, d, i, q, a, b, (vc.mode == 2'd1) ? "R7 R8" : "R2 R4 R5 R6 R8");
            end
            // R3: final dump, then an empty dump must read zero (R4)
            step(1'b0, 1'b1, 3, 3, 1'b1, 1'b1, "R3 dump");
            step(1'b0, 1'b1, 0, 0, 1'b0, 1'b0, "R4 empty");
            step(1'b0, 1'b0, 2, 2, 1'b1, 1'b0, "R3 hold");
        end

        // R1: reset after activity clears results
        ofs_a = 5'd0; spc_a = 4'd0; sel = 5'b00000;
        do_reset();
        for (int s = 0; s < 10; s++) step(1'b1, 1'b0, 2, -3, 1'b1, 1'b0, "R2 pre");
        step(1'b0, 1'b1, 0, 0, 1'b0, 1'b0, "R3 pre dump");
        do_reset();
        check_outs("R1 after activity");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule